// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 52-bit physical address by walking a four-level radix page table held in memory. A request carries the virtual address and two attributes: whether the access is a write and whether it comes from user mode. The walker first checks that the address is canonical. It then reads one 64-bit entry per level through a request/response memory port, starting from the table whose frame number is on the root input. At each level it checks the present bit and folds the user and write permission bits into a running AND.

A walk can stop at the second level, which maps a 1 GB page, or at the third level, which maps a 2 MB page, when the page-size bit of that entry is set. A successful walk is followed by a write-back pass. This pass sets the accessed flag in every entry the walk used and sets the dirty flag in the final entry on a write. The result is a one-cycle response carrying either the physical address with a size code, or a fault code with the level at which the fault arose. One request is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: An address whose bits 63:48 are not all equal to bit 47 is accepted and answered in the cycle after acceptance with fault code 1 and fault level 0, with no memory request.
- R2: The entry read at level n (n = 1..4) is at physical address {table frame, index, 3'b000}. The level-1 table frame comes from the root input and each later table frame is bits 51:12 of the previous entry. The indices are virtual address bits 47:39, 38:30, 29:21 and 20:12 for levels 1 to 4.
- R3: A walk that ends at level 4 returns physical address {entry bits 51:12, VA bits 11:0} with size code 0 and fault code 0.
- R4: A present level-3 entry with bit 7 set ends the walk after three reads. It returns {entry bits 51:21, VA bits 20:0} with size code 1.
- R5: A present level-2 entry with bit 7 set ends the walk after two reads. It returns {entry bits 51:30, VA bits 29:0} with size code 2.
- R6: Bit 7 of a level-1 entry has no effect; the walk continues to the next level.
- R7: An entry with bit 0 (present) clear ends the walk with fault code 2 and fault level equal to that entry's level (1..4), with no write-back.
- R8: The user permission is the AND of bit 2 and the write permission is the AND of bit 1 over all visited entries. A user access without user permission, or a write without write permission, ends the walk with fault code 3, the leaf level as fault level, and no write-back.
- R9: After a successful walk, every visited entry with bit 5 (accessed) clear is written back with bit 5 set, in order from level 1 to the leaf.
- R10: On a successful write access, the leaf entry is written back with bit 6 (dirty) set.
- R11: An entry whose flags need no change is not written, and the write-back pass spends one cycle on it.
- R12: reqReady is high only while idle, and rspValid is a single-cycle pulse followed by the idle state.
- R13: Once memReqValid rises, it and the request address and direction are held until memRspValid is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rootFrame | input | 40 | Frame number of the level-1 table |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle, request accepted when valid |
| reqVa | input | 64 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access comes from user mode |
| memReqValid | output | 1 | Memory access pending |
| memReqWrite | output | 1 | Pending access is a write |
| memReqAddr | output | 52 | Physical byte address of the entry |
| memReqWdata | output | 64 | Entry value to write |
| memRspValid | input | 1 | Memory access completes this cycle |
| memRspRdata | input | 64 | Entry value read |
| rspValid | output | 1 | Result valid (one cycle) |
| rspFaultCode | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 permission |
| rspFaultLevel | output | 3 | Level of the fault, 0 for non-canonical |
| rspPa | output | 52 | Translated physical address |
| rspSize | output | 2 | 0 for 4 KB, 1 for 2 MB, 2 for 1 GB |

## Verification
The result of a non-canonical request is due in the first cycle after acceptance. Every memory access costs the memory latency plus one cycle, and every write-back level that needs no write costs one cycle. A walk's result is therefore due at three cycles per read and per write plus one cycle per skipped level, with the model's two-cycle latency. Each scenario computes that cycle count from the entries it built and compares it with the number of falling edges counted from acceptance to rspValid. Results and write logs are sampled on falling edges only.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 64;
  localparam int SIG_W   = 48;
  localparam int PA_W    = 52;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int LEVELS  = 4;
  localparam int PTE_W   = 64;
  localparam int ENT_SH  = 3;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LVL_W   = $clog2(LEVELS);

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_BIG   = 7;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_ABSENT   = 2'd2,
    FLT_PERM     = 2'd3
  } fault_e;

  typedef struct packed {
    logic   latchReq;
    logic   capture;
    logic   memWr;
    logic   setOk;
    logic   setFault;
    fault_e code;
  } ctrl_s;

  typedef struct packed {
    logic canonical;
    logic present;
    logic leaf;
    logic permOk;
    logic needWb;
    logic lastWb;
  } stat_s;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             memReqValid,
  output logic             memReqWrite,
  input  logic             memRspValid,
  output logic             rspValid,
  input  stat_s            st,
  output ctrl_s            ctl,
  output logic [LVL_W-1:0] ctlLvl
);
  typedef enum logic [2:0] {
    S_IDLE, S_L1, S_L2, S_L3, S_L4, S_WB, S_DONE
  } state_e;

  state_e           state, nextState;
  logic [LVL_W-1:0] wbLvl, wbLvlNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      wbLvl <= '0;
    end else begin
      state <= nextState;
      wbLvl <= wbLvlNext;
    end
  end

  // level tied to each walk state; write-back uses its own counter
  always_comb begin
    case (state)
      S_L2:    ctlLvl = LVL_W'(1);
      S_L3:    ctlLvl = LVL_W'(2);
      S_L4:    ctlLvl = LVL_W'(3);
      S_WB:    ctlLvl = wbLvl;
      default: ctlLvl = '0;
    endcase
  end

  always_comb begin
    ctl         = '0;
    nextState   = state;
    wbLvlNext   = wbLvl;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    rspValid    = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          if (!st.canonical) begin
            ctl.setFault = 1'b1;
            ctl.code     = FLT_NONCANON;
            nextState    = S_DONE;
          end else begin
            nextState = S_L1;
          end
        end
      end
      S_L1, S_L2, S_L3, S_L4: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          ctl.capture = 1'b1;
          if (!st.present) begin
            ctl.setFault = 1'b1;
            ctl.code     = FLT_ABSENT;
            nextState    = S_DONE;
          end else if (st.leaf) begin
            if (!st.permOk) begin
              ctl.setFault = 1'b1;
              ctl.code     = FLT_PERM;
              nextState    = S_DONE;
            end else begin
              ctl.setOk = 1'b1;
              wbLvlNext = '0;
              nextState = S_WB;
            end
          end else begin
            case (state)
              S_L1:    nextState = S_L2;
              S_L2:    nextState = S_L3;
              default: nextState = S_L4;
            endcase
          end
        end
      end
      S_WB: begin
        if (st.needWb) begin
          memReqValid = 1'b1;
          memReqWrite = 1'b1;
          ctl.memWr   = 1'b1;
        end
        if (!st.needWb || memRspValid) begin
          if (st.lastWb) nextState = S_DONE;
          else           wbLvlNext = wbLvl + LVL_W'(1);
        end
      end
      S_DONE: begin
        rspValid  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              ctl,
  input  logic [LVL_W-1:0]   ctlLvl,
  output stat_s              st,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic [FRAME_W-1:0] rootFrame,
  input  logic [PTE_W-1:0]   memRspRdata,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [PTE_W-1:0]   memReqWdata,
  output logic [1:0]         rspFaultCode,
  output logic [2:0]         rspFaultLevel,
  output logic [PA_W-1:0]    rspPa,
  output logic [1:0]         rspSize
);
  logic [SIG_W-1:0]   vaR;
  logic               wrR, usrR, permUR, permWR;
  logic [FRAME_W-1:0] baseR;
  logic [LVL_W-1:0]   leafLvlR;
  logic [PTE_W-1:0]   entR  [LEVELS];
  logic [PA_W-1:0]    addrR [LEVELS];
  logic [IDX_W-1:0]   idxOf [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : gIdx
    assign idxOf[g] = vaR[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  logic [PA_W-1:0]  rdAddr, paMask, paNew;
  logic [PTE_W-1:0] wbEnt, wbNew;
  logic             effU, effW, wbIsLeaf;

  assign rdAddr = {baseR, idxOf[ctlLvl], ENT_SH'(0)};
  assign effU   = permUR & memRspRdata[B_USR];
  assign effW   = permWR & memRspRdata[B_WR];

  // offset width grows by one index per level above the last
  assign paMask = {PA_W{1'b1}} << (OFF_W + IDX_W*(LEVELS-1-int'(ctlLvl)));
  assign paNew  = (memRspRdata[PA_W-1:0] & paMask)
                | ({{(PA_W-SIG_W){1'b0}}, vaR} & ~paMask);

  assign wbEnt    = entR[ctlLvl];
  assign wbIsLeaf = (ctlLvl == leafLvlR);
  assign wbNew    = wbEnt | (PTE_W'(1) << B_ACC)
                  | ((wbIsLeaf && wrR) ? (PTE_W'(1) << B_DIRTY) : '0);

  always_comb begin
    st.canonical = (&reqVa[VA_W-1:SIG_W-1]) || !(|reqVa[VA_W-1:SIG_W-1]);
    st.present   = memRspRdata[B_PRES];
    st.leaf      = (ctlLvl == LVL_W'(LEVELS-1))
                 || ((ctlLvl != '0) && memRspRdata[B_BIG]);
    st.permOk    = !(usrR && !effU) && !(wrR && !effW);
    st.needWb    = (wbNew != wbEnt);
    st.lastWb    = wbIsLeaf;
  end

  assign memReqAddr  = ctl.memWr ? addrR[ctlLvl] : rdAddr;
  assign memReqWdata = wbNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR           <= '0;
      wrR           <= 1'b0;
      usrR          <= 1'b0;
      permUR        <= 1'b0;
      permWR        <= 1'b0;
      baseR         <= '0;
      leafLvlR      <= '0;
      rspFaultCode  <= FLT_NONE;
      rspFaultLevel <= '0;
      rspPa         <= '0;
      rspSize       <= '0;
      for (int i = 0; i < LEVELS; i++) begin
        entR[i]  <= '0;
        addrR[i] <= '0;
      end
    end else begin
      if (ctl.latchReq) begin
        vaR    <= reqVa[SIG_W-1:0];
        wrR    <= reqWrite;
        usrR   <= reqUser;
        permUR <= 1'b1;
        permWR <= 1'b1;
        baseR  <= rootFrame;
      end
      if (ctl.capture) begin
        entR[ctlLvl]  <= memRspRdata;
        addrR[ctlLvl] <= rdAddr;
        baseR         <= memRspRdata[PA_W-1:OFF_W];
        permUR        <= effU;
        permWR        <= effW;
      end
      if (ctl.setOk) begin
        leafLvlR      <= ctlLvl;
        rspFaultCode  <= FLT_NONE;
        rspFaultLevel <= '0;
        rspPa         <= paNew;
        rspSize       <= 2'(LEVELS-1) - 2'(ctlLvl);
      end
      if (ctl.setFault) begin
        rspFaultCode  <= ctl.code;
        rspFaultLevel <= (ctl.code == FLT_NONCANON) ? 3'd0 : ({1'b0, ctlLvl} + 3'd1);
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [FRAME_W-1:0] rootFrame,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  input  logic               reqUser,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [PTE_W-1:0]   memReqWdata,
  input  logic               memRspValid,
  input  logic [PTE_W-1:0]   memRspRdata,
  output logic               rspValid,
  output logic [1:0]         rspFaultCode,
  output logic [2:0]         rspFaultLevel,
  output logic [PA_W-1:0]    rspPa,
  output logic [1:0]         rspSize
);
  ctrl_s            ctl;
  stat_s            st;
  logic [LVL_W-1:0] ctlLvl;

  ptw_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memRspValid(memRspValid), .rspValid(rspValid),
    .st(st), .ctl(ctl), .ctlLvl(ctlLvl)
  );

  ptw_dpath uDpath (
    .clk(clk), .rstN(rstN),
    .ctl(ctl), .ctlLvl(ctlLvl), .st(st),
    .reqVa(reqVa), .reqWrite(reqWrite), .reqUser(reqUser),
    .rootFrame(rootFrame), .memRspRdata(memRspRdata),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .rspFaultCode(rspFaultCode), .rspFaultLevel(rspFaultLevel),
    .rspPa(rspPa), .rspSize(rspSize)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [16:0] vaTop,
  input logic        memReqValid,
  input logic        memReqWrite,
  input logic [51:0] memReqAddr,
  input logic [6:0]  wdFlags,
  input logic        memRspValid,
  input logic        rspValid,
  input logic [1:0]  rspFaultCode,
  input logic [2:0]  rspFaultLevel
);
  logic canon;
  assign canon = (&vaTop) || !(|vaTop);

  // R12
  busy_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  // R1
  noncanon_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !canon) |=>
      (rspValid && rspFaultCode == 2'd1 && rspFaultLevel == 3'd0));

  // R1
  noncanon_nomem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !canon) |=> !memReqValid);

  // R9
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (wdFlags[5] && wdFlags[0]));

  // R7
  absent_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFaultCode == 2'd2) |->
      (rspFaultLevel >= 3'd1 && rspFaultLevel <= 3'd4));
endmodule

bind pt_walker ptw_chk uChk (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqReady(reqReady),
  .vaTop(reqVa[63:47]),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memReqAddr(memReqAddr), .wdFlags(memReqWdata[6:0]),
  .memRspValid(memRspValid), .rspValid(rspValid),
  .rspFaultCode(rspFaultCode), .rspFaultLevel(rspFaultLevel)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int MEM_LAT = 2;
  localparam int WORDS   = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] rootFrame = 40'd1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVa = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid, memReqWrite, memRspValid;
  logic [51:0] memReqAddr;
  logic [63:0] memReqWdata, memRspRdata;
  logic        rspValid;
  logic [1:0]  rspFaultCode, rspSize;
  logic [2:0]  rspFaultLevel;
  logic [51:0] rspPa;

  always #2 clk = ~clk;

  pt_walker uut (.*);

  // memory model: reads from mem, logs writes
  logic [63:0] mem [WORDS];
  logic [3:0]  memCnt = '0;
  int          rdCount = 0, wrCount = 0;
  logic [51:0] wlogAddr [16];
  logic [63:0] wlogData [16];

  assign memRspValid = memReqValid && (memCnt == 4'(MEM_LAT));
  assign memRspRdata = mem[memReqAddr[15:3]];

  always @(posedge clk) begin
    if (!rstN) memCnt <= '0;
    else if (memReqValid) begin
      if (memRspValid) begin
        memCnt <= '0;
        if (memReqWrite) begin
          wlogAddr[wrCount % 16] <= memReqAddr;
          wlogData[wrCount % 16] <= memReqWdata;
          wrCount <= wrCount + 1;
        end else rdCount <= rdCount + 1;
      end else memCnt <= memCnt + 4'd1;
    end
  end

  int checks = 0, fails = 0;

  task automatic checkEq(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkVa(int i1, int i2, int i3, int i4, int off);
    logic [47:0] v;
    v = {i1[8:0], i2[8:0], i3[8:0], i4[8:0], off[11:0]};
    return {{16{v[47]}}, v};
  endfunction

  function automatic logic [63:0] pte(logic [39:0] fr, logic [11:0] fl);
    return {12'h0, fr, fl};
  endfunction

  task automatic clearMem();
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  endtask

  localparam logic [39:0] LEAF = 40'h12_3456_789A;

  // tables on pages 1..4, flags per level
  task automatic buildChain(int i1, int i2, int i3, int i4,
                            logic [11:0] f1, logic [11:0] f2,
                            logic [11:0] f3, logic [11:0] f4);
    clearMem();
    mem[1*512 + i1] = pte(40'd2, f1);
    mem[2*512 + i2] = pte(40'd3, f2);
    mem[3*512 + i3] = pte(40'd4, f3);
    mem[4*512 + i4] = pte(LEAF, f4);
  endtask

  logic [1:0]  rCode, rSize;
  logic [2:0]  rLvl;
  logic [51:0] rPa;
  int          rCyc, rReads, rWrites, wBase;

  task automatic runWalk(logic [63:0] va, logic wr, logic usr);
    int r0, w0, cyc;
    @(negedge clk);
    r0 = rdCount; w0 = wrCount;
    reqVa = va; reqWrite = wr; reqUser = usr; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!rspValid && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    rCode = rspFaultCode; rLvl = rspFaultLevel; rPa = rspPa; rSize = rspSize;
    rCyc = cyc; rReads = rdCount - r0; rWrites = wrCount - w0; wBase = w0;
  endtask

  localparam logic [11:0] FULL = 12'h027;

  task automatic tReset();
    checkEq("R12", "reqReady after reset", 64'(reqReady), 64'd1);
    checkEq("R12", "rspValid after reset", 64'(rspValid), 64'd0);
    checkEq("R13", "memReqValid after reset", 64'(memReqValid), 64'd0);
  endtask

  task automatic tPage4k();
    buildChain(3, 5, 7, 9, FULL, FULL, FULL, FULL);
    runWalk(mkVa(3, 5, 7, 9, 12'hABC), 1'b0, 1'b0);
    checkEq("R3", "4k pa", 64'(rPa), 64'({LEAF, 12'hABC}));
    checkEq("R3", "4k size", 64'(rSize), 64'd0);
    checkEq("R3", "4k code", 64'(rCode), 64'd0);
    checkEq("R2", "4k reads", 64'(rReads), 64'd4);
    checkEq("R11", "4k no writes", 64'(rWrites), 64'd0);
    checkEq("R11", "4k latency", 64'(rCyc), 64'd16);
  endtask

  task automatic tUserWriteFresh();
    buildChain(1, 2, 3, 4, 12'h007, 12'h007, 12'h007, 12'h007);
    runWalk(mkVa(1, 2, 3, 4, 12'h010), 1'b1, 1'b1);
    checkEq("R9", "fresh code", 64'(rCode), 64'd0);
    checkEq("R9", "fresh pa", 64'(rPa), 64'({LEAF, 12'h010}));
    checkEq("R9", "fresh writes", 64'(rWrites), 64'd4);
    checkEq("R9", "fresh latency", 64'(rCyc), 64'd24);
    checkEq("R9", "wb L1 addr", 64'(wlogAddr[wBase % 16]), 64'(52'h1000 + 1*8));
    checkEq("R9", "wb L1 data", wlogData[wBase % 16], pte(40'd2, 12'h027));
    checkEq("R9", "wb L2 addr", 64'(wlogAddr[(wBase+1) % 16]), 64'(52'h2000 + 2*8));
    checkEq("R9", "wb L3 data", wlogData[(wBase+2) % 16], pte(40'd4, 12'h027));
    checkEq("R10", "wb leaf addr", 64'(wlogAddr[(wBase+3) % 16]), 64'(52'h4000 + 4*8));
    checkEq("R10", "wb leaf data", wlogData[(wBase+3) % 16], pte(LEAF, 12'h067));
  endtask

  task automatic tDirtyOnly();
    buildChain(1, 2, 3, 4, FULL, FULL, FULL, FULL);
    runWalk(mkVa(1, 2, 3, 4, 0), 1'b1, 1'b0);
    checkEq("R10", "dirty-only writes", 64'(rWrites), 64'd1);
    checkEq("R10", "dirty-only data", wlogData[wBase % 16], pte(LEAF, 12'h067));
    checkEq("R11", "dirty-only latency", 64'(rCyc), 64'd18);
  endtask

  task automatic tPage2m();
    buildChain(3, 5, 7, 9, FULL, FULL, FULL | 12'h080, 12'h000);
    mem[3*512 + 7] = pte(LEAF, FULL | 12'h080);
    runWalk(mkVa(3, 5, 7, 9, 12'hABC), 1'b0, 1'b0);
    checkEq("R4", "2m pa", 64'(rPa), 64'({LEAF[39:9], 9'd9, 12'hABC}));
    checkEq("R4", "2m size", 64'(rSize), 64'd1);
    checkEq("R4", "2m reads", 64'(rReads), 64'd3);
    checkEq("R4", "2m latency", 64'(rCyc), 64'd12);
  endtask

  task automatic tPage1g();
    buildChain(3, 5, 7, 9, FULL, FULL, FULL, FULL);
    mem[2*512 + 5] = pte(LEAF, FULL | 12'h080);
    runWalk(mkVa(3, 5, 7, 9, 12'hABC), 1'b0, 1'b0);
    checkEq("R5", "1g pa", 64'(rPa), 64'({LEAF[39:18], 9'd7, 9'd9, 12'hABC}));
    checkEq("R5", "1g size", 64'(rSize), 64'd2);
    checkEq("R5", "1g reads", 64'(rReads), 64'd2);
    checkEq("R5", "1g latency", 64'(rCyc), 64'd8);
  endtask

  task automatic tBigAtTop();
    buildChain(3, 5, 7, 9, FULL | 12'h080, FULL, FULL, FULL);
    runWalk(mkVa(3, 5, 7, 9, 12'h123), 1'b0, 1'b0);
    checkEq("R6", "L1 big bit size", 64'(rSize), 64'd0);
    checkEq("R6", "L1 big bit pa", 64'(rPa), 64'({LEAF, 12'h123}));
    checkEq("R6", "L1 big bit reads", 64'(rReads), 64'd4);
  endtask

  task automatic tAbsent();
    buildChain(3, 5, 7, 9, FULL, FULL, 12'h026, FULL);
    runWalk(mkVa(3, 5, 7, 9, 0), 1'b1, 1'b0);
    checkEq("R7", "absent code", 64'(rCode), 64'd2);
    checkEq("R7", "absent level", 64'(rLvl), 64'd3);
    checkEq("R7", "absent writes", 64'(rWrites), 64'd0);
    checkEq("R7", "absent latency", 64'(rCyc), 64'd9);
    buildChain(3, 5, 7, 9, 12'h006, FULL, FULL, FULL);
    runWalk(mkVa(3, 5, 7, 9, 0), 1'b0, 1'b0);
    checkEq("R7", "absent L1 level", 64'(rLvl), 64'd1);
  endtask

  task automatic tPerm();
    buildChain(3, 5, 7, 9, 12'h007, 12'h003, 12'h007, 12'h007);
    runWalk(mkVa(3, 5, 7, 9, 0), 1'b0, 1'b1);
    checkEq("R8", "user denied code", 64'(rCode), 64'd3);
    checkEq("R8", "user denied level", 64'(rLvl), 64'd4);
    checkEq("R8", "user denied writes", 64'(rWrites), 64'd0);
    checkEq("R8", "user denied latency", 64'(rCyc), 64'd12);
    runWalk(mkVa(3, 5, 7, 9, 0), 1'b0, 1'b0);
    checkEq("R8", "supervisor ok code", 64'(rCode), 64'd0);
    buildChain(3, 5, 7, 9, FULL, FULL, FULL, 12'h025);
    runWalk(mkVa(3, 5, 7, 9, 0), 1'b1, 1'b0);
    checkEq("R8", "write denied code", 64'(rCode), 64'd3);
    checkEq("R8", "write denied writes", 64'(rWrites), 64'd0);
    runWalk(mkVa(3, 5, 7, 9, 0), 1'b0, 1'b1);
    checkEq("R8", "read of ro page code", 64'(rCode), 64'd0);
  endtask

  task automatic tCanonical();
    runWalk(64'h0000_8000_0000_0000, 1'b0, 1'b0);
    checkEq("R1", "low noncanon code", 64'(rCode), 64'd1);
    checkEq("R1", "low noncanon level", 64'(rLvl), 64'd0);
    checkEq("R1", "low noncanon latency", 64'(rCyc), 64'd0);
    checkEq("R1", "low noncanon reads", 64'(rReads), 64'd0);
    runWalk(64'hFFFF_0000_0000_1000, 1'b0, 1'b0);
    checkEq("R1", "high noncanon code", 64'(rCode), 64'd1);
    buildChain(256, 5, 7, 9, FULL, FULL, FULL, FULL);
    runWalk(mkVa(256, 5, 7, 9, 12'h044), 1'b0, 1'b0);
    checkEq("R2", "upper half code", 64'(rCode), 64'd0);
    checkEq("R2", "upper half pa", 64'(rPa), 64'({LEAF, 12'h044}));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPage4k();
    tUserWriteFresh();
    tDirtyOnly();
    tPage2m();
    tPage1g();
    tBigAtTop();
    tAbsent();
    tPerm();
    tCanonical();
    finishRun();
  end
endmodule